// File: doc/BRIEF.md
# I2C Master Address Phase Sequencer

This block runs the addressing part of an I2C master transfer. Software-side logic loads a slave address, an addressing width (7-bit or 10-bit), a direction and a flag that picks the short 10-bit read form. It then raises a start request. The sequencer turns that setting into an ordered list of bus commands: START, repeated START, or send one byte. It hands these one at a time to a byte-level bit engine. After each byte it waits for the engine's acknowledge report. It then moves on, aborts, or finishes.

Commands leave on a valid/ready stream. `cmd_valid` stays high, with `cmd_op` and `cmd_byte` unchanged, until the engine takes the command by holding `cmd_ready` high on a rising edge. The engine may stall for any number of cycles. Acknowledge results come back on a second valid/ready stream. `ack_ready` is high only while the sequencer waits for the result of a byte it has sent. A result presented at any other time is held off by the engine and is not lost. The configuration inputs, the start request and the done, NACK and busy flags are plain pins.

Bit timing, the data phase, STOP, clock stretching and arbitration belong to the bit engine or to later stages.

Top module: `i2c_addr_seq`

## Requirements
- R1: With `cfg_mode10`=0, the sequence is START (cmd_op 0) followed by one send (cmd_op 2) of byte {addr[7:1], rw}. Here rw=1 for read, and addr[9:8] and addr[0] have no effect.
- R2: With `cfg_mode10`=1 and `cfg_read`=0, the sequence is START, then send {5'b11110, addr[9:8], 1'b0}, then send addr[7:0]. `cfg_hdr_only` has no effect in this case.
- R3: With `cfg_mode10`=1, `cfg_read`=1 and `cfg_hdr_only`=0, the sequence is START, the write header, addr[7:0], repeated START (cmd_op 1), and then the read header {5'b11110, addr[9:8], 1'b1}.
- R4: With `cfg_mode10`=1, `cfg_read`=1 and `cfg_hdr_only`=1, the sequence is only a repeated START followed by the read header.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op` and `cmd_byte` hold their values in the next cycle.
- R6: After a send is accepted, no further command is offered until an acknowledge is accepted. `ack_ready` is high only in that waiting window and never together with `cmd_valid`.
- R7: An acknowledge with `ack_nack`=1 ends the sequence. `nack` pulses for exactly one cycle, in the cycle after the acknowledge is accepted. `busy` is low in that cycle and no further command is offered.
- R8: When the last address byte is acknowledged with `ack_nack`=0, `done` pulses for exactly one cycle, in the following cycle, with `busy` low.
- R9: `start_set` raises `start_pend` in the next cycle if the block is idle with no pending request, and is ignored otherwise. `start_pend` clears on the edge where the first command of the sequence is accepted.
- R10: A `cfg_wr` strobe updates the stored setting only while `start_pend` and `busy` are both low. Otherwise it has no effect on the commands sent.
- R11: `busy` rises in the cycle after `start_pend` is first seen high, and falls in the cycle in which `done` or `nack` pulses.
- R12: After reset, `start_pend`, `busy`, `done`, `nack`, `cmd_valid` and `ack_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe that loads the four settings below |
| cfg_addr | input | 10 | Slave address field |
| cfg_mode10 | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| cfg_read | input | 1 | 1 = master receive, 0 = master transmit |
| cfg_hdr_only | input | 1 | 10-bit receive: send only repeated START and read header |
| start_set | input | 1 | Request a new address phase |
| start_pend | output | 1 | Start request outstanding |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: address phase completed |
| nack | output | 1 | One-cycle pulse: address byte not acknowledged |
| cmd_valid | output | 1 | Command offered to the bit engine |
| cmd_ready | input | 1 | Bit engine takes the command |
| cmd_op | output | 2 | 0 START, 1 repeated START, 2 send byte |
| cmd_byte | output | 8 | Byte to send when cmd_op is 2 |
| ack_valid | input | 1 | Acknowledge result present |
| ack_ready | output | 1 | Sequencer waiting for an acknowledge |
| ack_nack | input | 1 | 1 = byte was not acknowledged |

## Verification
The following properties are checked on every cycle:
- command hold under back-pressure;
- mutual exclusion of the command and acknowledge windows;
- single-cycle `done` and `nack` pulses that coincide with idle;
- clearing of the start request on the first accepted command;
- freezing of the stored setting while a request is pending or a sequence runs;
- the 7-bit byte layout.

The exact order and content of each sequence can only be shown by the bench's scenarios, which compare every accepted command with a per-mode model. The same applies to the short 10-bit read form, the abort after a NACK at different byte positions, and the dropping of writes and repeated start requests made mid-sequence.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;
  localparam logic [4:0] HDR10_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_SEND    = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              mode10;
    logic              rd;
    logic              hdr_only;
  } cfg_t;
endpackage

// File: rtl/aseq_cfg.sv
module aseq_cfg
  import i2c_aseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  cfg_t wr_cfg,
  input  logic start_set,
  input  logic busy,
  input  logic first_acc,
  output cfg_t cfg_q,
  output logic pend
);
  logic lock;
  assign lock = pend | busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr && !lock) begin
      cfg_q <= wr_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (first_acc) begin
      pend <= 1'b0;
    end else if (start_set && !lock) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/aseq_plan.sv
module aseq_plan
  import i2c_aseq_pkg::*;
(
  input  cfg_t              cfg,
  input  logic [STEP_W-1:0] step,
  output op_e               op,
  output logic [BYTE_W-1:0] byte_o,
  output logic              last
);
  logic [BYTE_W-1:0] hdr_w, hdr_r, lo_byte, b7;

  assign hdr_w   = {HDR10_PREFIX, cfg.addr[9:8], 1'b0};
  assign hdr_r   = {HDR10_PREFIX, cfg.addr[9:8], 1'b1};
  assign lo_byte = cfg.addr[7:0];
  assign b7      = {cfg.addr[7:1], cfg.rd};

  always_comb begin
    op     = OP_SEND;
    byte_o = '0;
    last   = 1'b0;
    if (!cfg.mode10) begin
      case (step)
        3'd0: op = OP_START;
        3'd1: begin byte_o = b7; last = 1'b1; end
        default: ;
      endcase
    end else if (!cfg.rd) begin
      case (step)
        3'd0: op = OP_START;
        3'd1: byte_o = hdr_w;
        3'd2: begin byte_o = lo_byte; last = 1'b1; end
        default: ;
      endcase
    end else if (cfg.hdr_only) begin
      case (step)
        3'd0: op = OP_RESTART;
        3'd1: begin byte_o = hdr_r; last = 1'b1; end
        default: ;
      endcase
    end else begin
      case (step)
        3'd0: op = OP_START;
        3'd1: byte_o = hdr_w;
        3'd2: byte_o = lo_byte;
        3'd3: op = OP_RESTART;
        3'd4: begin byte_o = hdr_r; last = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl
  import i2c_aseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  op_e               op,
  input  logic              last,
  input  logic              cmd_ready,
  input  logic              ack_valid,
  input  logic              ack_nack,
  output logic [STEP_W-1:0] step,
  output logic              cmd_valid,
  output logic              ack_ready,
  output logic              busy,
  output logic              first_acc,
  output logic              done,
  output logic              nack
);
  phase_e ph;
  logic   cmd_hs, ack_hs;

  assign cmd_valid = (ph == PH_ISSUE);
  assign ack_ready = (ph == PH_WAIT);
  assign busy      = (ph != PH_IDLE);
  assign cmd_hs    = cmd_valid & cmd_ready;
  assign ack_hs    = ack_ready & ack_valid;
  assign first_acc = cmd_hs & (step == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      step <= '0;
      done <= 1'b0;
      nack <= 1'b0;
    end else begin
      done <= 1'b0;
      nack <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (pend) begin
            ph   <= PH_ISSUE;
            step <= '0;
          end
        end
        PH_ISSUE: begin
          if (cmd_hs) begin
            if (op == OP_SEND) ph <= PH_WAIT;
            else step <= step + 1'b1;
          end
        end
        PH_WAIT: begin
          if (ack_hs) begin
            if (ack_nack) begin
              nack <= 1'b1;
              ph   <= PH_IDLE;
            end else if (last) begin
              done <= 1'b1;
              ph   <= PH_IDLE;
            end else begin
              step <= step + 1'b1;
              ph   <= PH_ISSUE;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [9:0]  cfg_addr,
  input  logic        cfg_mode10,
  input  logic        cfg_read,
  input  logic        cfg_hdr_only,
  input  logic        start_set,
  output logic        start_pend,
  output logic        busy,
  output logic        done,
  output logic        nack,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  input  logic        ack_valid,
  output logic        ack_ready,
  input  logic        ack_nack
);
  cfg_t              wr_cfg, cfg_q;
  logic              first_acc, last;
  logic [STEP_W-1:0] step;
  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_m10;

  assign wr_cfg   = '{addr: cfg_addr, mode10: cfg_mode10, rd: cfg_read, hdr_only: cfg_hdr_only};
  assign cur_addr = cfg_q.addr;
  assign cur_m10  = cfg_q.mode10;
  assign cmd_op   = op;

  aseq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_cfg(wr_cfg),
    .start_set(start_set), .busy(busy), .first_acc(first_acc),
    .cfg_q(cfg_q), .pend(start_pend)
  );

  aseq_plan u_plan (
    .cfg(cfg_q), .step(step), .op(op), .byte_o(cmd_byte), .last(last)
  );

  aseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pend(start_pend), .op(op), .last(last),
    .cmd_ready(cmd_ready), .ack_valid(ack_valid), .ack_nack(ack_nack),
    .step(step), .cmd_valid(cmd_valid), .ack_ready(ack_ready), .busy(busy),
    .first_acc(first_acc), .done(done), .nack(nack)
  );
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_pend,
  input logic       busy,
  input logic       done,
  input logic       nack,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_byte,
  input logic       ack_ready,
  input logic [9:0] cur_addr,
  input logic       cur_m10
);
  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));

  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && ack_ready));

  a_r7_nack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> !busy && !cmd_valid && !done);

  a_r7_nack_once: assert property (@(posedge clk) disable iff (!rst_n)
    nack |=> !nack);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_pend && cmd_valid && cmd_ready |=> !start_pend);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pend || busy) |=> $stable(cur_addr) && $stable(cur_m10));

  a_r1_byte7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd2 && !cur_m10 |-> cmd_byte[7:1] == cur_addr[7:1]);

  a_r11_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_pend(start_pend), .busy(busy),
  .done(done), .nack(nack), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .ack_ready(ack_ready),
  .cur_addr(cur_addr), .cur_m10(cur_m10)
);

// File: tb/sim_i2c_addr_seq.sv
module sim_i2c_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_mode10 = 0, cfg_read = 0, cfg_hdr_only = 0, start_set = 0;
  logic [9:0] cfg_addr = '0;
  logic start_pend, busy, done, nack, cmd_valid, ack_ready;
  logic cmd_ready = 0, ack_valid = 0, ack_nack = 0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_byte;

  always #2 clk = ~clk;

  i2c_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_mode10(cfg_mode10), .cfg_read(cfg_read), .cfg_hdr_only(cfg_hdr_only),
    .start_set(start_set), .start_pend(start_pend), .busy(busy), .done(done),
    .nack(nack), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_nack(ack_nack)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  int m_phase = 0;             // 0 idle, 1 offering, 2 waiting ack
  bit m_pend = 0, m_done = 0, m_nack = 0, m_first = 0;
  bit [9:0] m_addr = 0;
  bit m_m10 = 0, m_rd = 0, m_hdr = 0;
  int q_op[$];
  int q_byte[$];
  string m_tag = "R1";
  // engine model
  int nack_at = -1, send_idx = 0, ack_cnt = 0;
  bit ack_armed = 0, ack_nk = 0;
  bit [15:0] lfsr = 16'hACE1;
  int done_seen = 0, nack_seen = 0;

  task automatic build_queue();
    bit [7:0] hw, hr;
    hw = {5'b11110, m_addr[9:8], 1'b0};
    hr = {5'b11110, m_addr[9:8], 1'b1};
    q_op.delete(); q_byte.delete();
    if (!m_m10) begin
      m_tag = "R1";
      q_op.push_back(0); q_byte.push_back(-1);
      q_op.push_back(2); q_byte.push_back({m_addr[7:1], m_rd});
    end else if (!m_rd) begin
      m_tag = "R2";
      q_op.push_back(0); q_byte.push_back(-1);
      q_op.push_back(2); q_byte.push_back(hw);
      q_op.push_back(2); q_byte.push_back(m_addr[7:0]);
    end else if (m_hdr) begin
      m_tag = "R4";
      q_op.push_back(1); q_byte.push_back(-1);
      q_op.push_back(2); q_byte.push_back(hr);
    end else begin
      m_tag = "R3";
      q_op.push_back(0); q_byte.push_back(-1);
      q_op.push_back(2); q_byte.push_back(hw);
      q_op.push_back(2); q_byte.push_back(m_addr[7:0]);
      q_op.push_back(1); q_byte.push_back(-1);
      q_op.push_back(2); q_byte.push_back(hr);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      m_phase = 0; m_pend = 0; m_done = 0; m_nack = 0;
      m_addr = 0; m_m10 = 0; m_rd = 0; m_hdr = 0;
      cmd_ready = 0; ack_valid = 0; ack_armed = 0;
    end else begin
      bit cmd_hs, ack_hs, n_pend, n_done, n_nack;
      int n_phase;
      // compare this cycle against the model
      chk("R9",  "start_pend", start_pend, m_pend);
      chk("R11", "busy",       busy,       m_phase != 0);
      chk("R6",  "cmd_valid",  cmd_valid,  m_phase == 1);
      chk("R6",  "ack_ready",  ack_ready,  m_phase == 2);
      chk("R8",  "done",       done,       m_done);
      chk("R7",  "nack",       nack,       m_nack);
      if (done) done_seen++;
      if (nack) nack_seen++;
      if (cmd_valid && q_op.size() > 0) begin
        chk(m_tag, "cmd_op", cmd_op, q_op[0]);
        if (q_op[0] == 2) chk(m_tag, "cmd_byte", cmd_byte, q_byte[0]);
      end
      // engine drive for the coming edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = lfsr[0] | lfsr[3];
      if (ack_armed && ack_cnt > 0) ack_cnt--;
      ack_valid = ack_armed && ack_cnt == 0;
      ack_nack  = ack_valid ? ack_nk : lfsr[5];
      cmd_hs = cmd_valid && cmd_ready;
      ack_hs = ack_valid && ack_ready;
      // model next state
      n_pend = m_pend; n_phase = m_phase; n_done = 0; n_nack = 0;
      if (cfg_wr && !m_pend && m_phase == 0) begin
        m_addr = cfg_addr; m_m10 = cfg_mode10; m_rd = cfg_read; m_hdr = cfg_hdr_only;
      end
      if (start_set && !m_pend && m_phase == 0) n_pend = 1;
      case (m_phase)
        0: if (m_pend) begin n_phase = 1; build_queue(); m_first = 1; end
        1: if (cmd_hs) begin
             if (m_first) n_pend = 0;
             m_first = 0;
             if (q_op.size() > 0 && q_op[0] == 2) begin
               n_phase = 2;
               ack_armed = 1; ack_cnt = lfsr[2:1] % 3;
               ack_nk = (send_idx == nack_at);
               send_idx++;
             end
             if (q_op.size() > 0) begin void'(q_op.pop_front()); void'(q_byte.pop_front()); end
           end
        default: if (ack_hs) begin
             ack_armed = 0;
             if (ack_nk) begin n_nack = 1; n_phase = 0; q_op.delete(); q_byte.delete(); end
             else if (q_op.size() == 0) begin n_done = 1; n_phase = 0; end
             else n_phase = 1;
           end
      endcase
      m_pend = n_pend; m_phase = n_phase; m_done = n_done; m_nack = n_nack;
    end
  end

  task automatic run_seq(input bit [9:0] a, input bit m10, input bit rd, input bit hdr,
                         input int nk_at, input int exp_done, input int exp_nack, input string tag);
    int d0, n0;
    d0 = done_seen; n0 = nack_seen;
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_mode10 = m10; cfg_read = rd; cfg_hdr_only = hdr;
    nack_at = nk_at; send_idx = 0;
    @(negedge clk);
    cfg_wr = 0; start_set = 1;
    @(negedge clk);
    start_set = 0;
    // R10: write attempted while the request is pending
    cfg_wr = 1; cfg_addr = ~a; cfg_mode10 = ~m10; cfg_read = ~rd; cfg_hdr_only = ~hdr;
    @(negedge clk);
    cfg_wr = 0;
    start_set = 1;   // R9: ignored while busy
    @(negedge clk);
    start_set = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!busy && !start_pend && !done && !nack) break;
    end
    repeat (2) @(negedge clk);
    chk(tag, "done pulses", done_seen - d0, exp_done);
    chk(tag, "nack pulses", nack_seen - n0, exp_nack);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", "start_pend", start_pend, 0);
    chk("R12", "busy", busy, 0);
    chk("R12", "done", done, 0);
    chk("R12", "nack", nack, 0);
    chk("R12", "cmd_valid", cmd_valid, 0);
    chk("R12", "ack_ready", ack_ready, 0);
    run_seq(10'h3A5, 0, 0, 0, -1, 1, 0, "R1");
    run_seq(10'h0B2, 0, 1, 1, -1, 1, 0, "R1");
    run_seq(10'h2C7, 1, 0, 0, -1, 1, 0, "R2");
    run_seq(10'h1F0, 1, 0, 1, -1, 1, 0, "R2");
    run_seq(10'h1F0, 1, 1, 0, -1, 1, 0, "R3");
    run_seq(10'h36E, 1, 1, 1, -1, 1, 0, "R4");
    run_seq(10'h155, 1, 1, 0,  1, 0, 1, "R7");
    run_seq(10'h0AA, 0, 0, 0,  0, 0, 1, "R7");
    run_seq(10'h2D3, 1, 1, 0,  2, 0, 1, "R7");
    run_seq(10'h3FF, 1, 0, 0, -1, 1, 0, "R8");
    for (int k = 0; k < 20; k++)
      run_seq(10'(k * 37 + 5), k[0], k[1], k[2], (k % 5 == 4) ? 1 : -1,
              (k % 5 == 4 && (k[0] == 1'b1)) ? 0 : 1,
              (k % 5 == 4 && (k[0] == 1'b1)) ? 1 : 0, "R10");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule